// File: doc/BRIEF.md
# Twin Countdown Timer

A register-mapped peripheral with two independent 32-bit counters that count down. Software sets each counter up through a small synchronous register port: a reload value, a live count value, and a shared control word. The control word holds, for each counter, an enable, an auto-reload switch, a timebase choice and a prescaler exponent. With auto-reload set, a counter that passes zero reloads itself and keeps running (periodic). With auto-reload clear, it fires once and parks at zero (one-shot).

Two single-cycle tick inputs from the same clock domain act as timebases. One is a fixed reference tick that is used as it arrives. The other is a fabric tick that goes through a per-counter power-of-two prescaler. Every expiry sets a sticky flag in a shared status word, and each flag drives its own interrupt line as a level. Software clears a flag by writing zero to its bit.

A free-running up-count comes from loading all-ones into both the reload and value registers with auto-reload on, then reading the bitwise inverse of the value register.

Top module: `twin_countdown_timer`

## Requirements
- R1: The register map is: control at 0x00, status at 0x04, reload for counter 0 at 0x10, value for counter 0 at 0x14, reload for counter 1 at 0x18, value for counter 1 at 0x1C. The control and reload registers read back the last value written. Any other address reads as zero.
- R2: A write to a value register loads that counter on the next clock edge, and this takes priority over counting. A read of a value register returns the live count.
- R3: An enabled counter goes down by one on each count tick while its value is not zero.
- R4: A count tick that arrives while the count is 0 and auto-reload is on (control bit 1 for counter 0, bit 3 for counter 1) raises an event and loads the reload value.
- R5: A count tick that arrives while the count is 0 and auto-reload is off raises one event. The counter then stays at 0 and raises no further events until its value register is written again.
- R6: A counter whose enable is clear (control bit 0 for counter 0, bit 2 for counter 1) holds its value and raises no events, whatever its tick inputs do.
- R7: Control bit 11 (counter 0) or bit 12 (counter 1) set means the counter counts reference ticks and ignores fabric ticks. Clear means it counts prescaled fabric ticks and ignores reference ticks.
- R8: The prescaler exponent is a 3-bit field, at control bits 21:19 for counter 0 and bits 24:22 for counter 1. In fabric mode, one count tick occurs for every 2^exponent fabric ticks. The prescaler restarts whenever that counter's enable bit is written from 0 to 1.
- R9: Status bit 0 (counter 0) and bit 8 (counter 1) are set by an event and stay set. Writing 0 to a status bit clears it. Writing 1 to it leaves it unchanged.
- R10: irq[0] and irq[1] are the levels of status bits 0 and 8.
- R11: If an event and a clearing write to the same status bit land in the same cycle, the bit ends up set.
- R12: After reset, every register, count and status bit is zero and both interrupts are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| refTick | input | 1 | Fixed-reference tick enable, one cycle wide |
| fabricTick | input | 1 | Fabric tick enable, one cycle wide, prescaled per counter |
| regWe | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Byte address of the register |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, combinational from regAddr |
| irq | output | 2 | Interrupt level per counter |

## Verification
The bench drives counters across zero in both periodic and one-shot mode, including a start at zero and an all-ones free-running load. A counter that expired one tick late or early would show an off-by-one count or a missing flag. A one-shot counter that wrapped would fire twice after a clear. The bench lands a status clear in the same cycle as an expiry, where a design that let the clear win would lose the interrupt. It also writes 1 and 0 to the two status bits in turn, catching a design that clears on a written one. For the prescaler, the bench leaves a partial fabric count behind, re-enables the counter and then gives a single fabric tick: a prescaler that did not restart would produce a count tick there. Timebase selection is checked by pulsing the unselected tick and confirming that the count does not move.

// File: rtl/twin_timer_pkg.sv
package twin_timer_pkg;
  localparam int CNT_W   = 32;
  localparam int DIV_W   = 3;
  localparam int NUM_TMR = 2;
  localparam int PRE_W   = (1 << DIV_W) - 1;

  localparam int CTRL_ADDR = 'h00;
  localparam int STAT_ADDR = 'h04;

  // per-counter layout of the control and status words
  function automatic int enBit(input int i);    return 2 * i;        endfunction
  function automatic int autoBit(input int i);  return 2 * i + 1;    endfunction
  function automatic int refBit(input int i);   return 11 + i;       endfunction
  function automatic int divLsb(input int i);   return 19 + DIV_W * i; endfunction
  function automatic int statBit(input int i);  return 8 * i;        endfunction
  function automatic int reloadAddr(input int i); return 'h10 + 8 * i; endfunction
  function automatic int valueAddr(input int i);  return 'h14 + 8 * i; endfunction

  typedef struct packed {
    logic [NUM_TMR-1:0]            wrReload;
    logic [NUM_TMR-1:0]            wrValue;
    logic [NUM_TMR-1:0]            enable;
    logic [NUM_TMR-1:0]            autoReload;
    logic [NUM_TMR-1:0]            useRef;
    logic [NUM_TMR-1:0]            enRise;
    logic [NUM_TMR-1:0][DIV_W-1:0] divExp;
  } tmrCmd_t;
endpackage

// File: rtl/twin_timer_ctrl.sv
module twin_timer_ctrl
  import twin_timer_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          regWe,
  input  logic [ADDR_W-1:0]             regAddr,
  input  logic [CNT_W-1:0]              regWdata,
  output logic [CNT_W-1:0]              regRdata,
  input  logic [NUM_TMR-1:0]            expire,
  input  logic [NUM_TMR-1:0][CNT_W-1:0] countNow,
  input  logic [NUM_TMR-1:0][CNT_W-1:0] reloadNow,
  output tmrCmd_t                       cmd,
  output logic [NUM_TMR-1:0]            irq
);
  logic [CNT_W-1:0]   ctrlReg;
  logic [NUM_TMR-1:0] statusBits;
  logic               wrCtrl;
  logic               wrStat;

  assign wrCtrl = regWe && (regAddr == ADDR_W'(CTRL_ADDR));
  assign wrStat = regWe && (regAddr == ADDR_W'(STAT_ADDR));

  always_ff @(posedge clk) begin
    if (!rstN) ctrlReg <= '0;
    else if (wrCtrl) ctrlReg <= regWdata;
  end

  for (genvar gi = 0; gi < NUM_TMR; gi++) begin : g_slot
    // an expiry beats a same-cycle clear
    always_ff @(posedge clk) begin
      if (!rstN) statusBits[gi] <= 1'b0;
      else if (expire[gi]) statusBits[gi] <= 1'b1;
      else if (wrStat && !regWdata[statBit(gi)]) statusBits[gi] <= 1'b0;
    end

    assign cmd.wrReload[gi]   = regWe && (regAddr == ADDR_W'(reloadAddr(gi)));
    assign cmd.wrValue[gi]    = regWe && (regAddr == ADDR_W'(valueAddr(gi)));
    assign cmd.enable[gi]     = ctrlReg[enBit(gi)];
    assign cmd.autoReload[gi] = ctrlReg[autoBit(gi)];
    assign cmd.useRef[gi]     = ctrlReg[refBit(gi)];
    assign cmd.divExp[gi]     = ctrlReg[divLsb(gi) +: DIV_W];
    assign cmd.enRise[gi]     = wrCtrl && regWdata[enBit(gi)] && !ctrlReg[enBit(gi)];
    assign irq[gi]            = statusBits[gi];
  end

  always_comb begin
    regRdata = '0;
    if (regAddr == ADDR_W'(CTRL_ADDR)) regRdata = ctrlReg;
    for (int i = 0; i < NUM_TMR; i++) begin
      if (regAddr == ADDR_W'(STAT_ADDR))     regRdata[statBit(i)] = statusBits[i];
      if (regAddr == ADDR_W'(reloadAddr(i))) regRdata = reloadNow[i];
      if (regAddr == ADDR_W'(valueAddr(i)))  regRdata = countNow[i];
    end
  end
endmodule

// File: rtl/twin_timer_datapath.sv
module twin_timer_datapath
  import twin_timer_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          refTick,
  input  logic                          fabricTick,
  input  tmrCmd_t                       cmd,
  input  logic [CNT_W-1:0]              wrData,
  output logic [NUM_TMR-1:0][CNT_W-1:0] countNow,
  output logic [NUM_TMR-1:0][CNT_W-1:0] reloadNow,
  output logic [NUM_TMR-1:0]            expire
);
  for (genvar gi = 0; gi < NUM_TMR; gi++) begin : g_cnt
    logic [PRE_W-1:0] preCnt;
    logic [PRE_W-1:0] preMask;
    logic             countTick;
    logic             atZero;
    logic             parked;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] rel;

    assign preMask = PRE_W'((32'd1 << cmd.divExp[gi]) - 32'd1);

    always_ff @(posedge clk) begin
      if (!rstN) preCnt <= '0;
      else if (cmd.enRise[gi]) preCnt <= '0;
      else if (cmd.enable[gi] && !cmd.useRef[gi] && fabricTick) preCnt <= preCnt + 1'b1;
    end

    assign countTick = cmd.enable[gi] &&
                       (cmd.useRef[gi] ? refTick
                                       : (fabricTick && ((preCnt & preMask) == preMask)));
    assign atZero      = (cnt == '0);
    assign expire[gi]  = countTick && atZero && !parked;

    always_ff @(posedge clk) begin
      if (!rstN) rel <= '0;
      else if (cmd.wrReload[gi]) rel <= wrData;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cnt    <= '0;
        parked <= 1'b0;
      end else if (cmd.wrValue[gi]) begin
        cnt    <= wrData;
        parked <= 1'b0;
      end else if (countTick) begin
        if (!atZero) cnt <= cnt - 1'b1;
        else if (!parked) begin
          if (cmd.autoReload[gi]) cnt <= rel;
          else parked <= 1'b1;
        end
      end
    end

    assign countNow[gi]  = cnt;
    assign reloadNow[gi] = rel;
  end
endmodule

// File: rtl/twin_countdown_timer.sv
module twin_countdown_timer
  import twin_timer_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          refTick,
  input  logic                          fabricTick,
  input  logic                          regWe,
  input  logic [ADDR_W-1:0]             regAddr,
  input  logic [twin_timer_pkg::CNT_W-1:0] regWdata,
  output logic [twin_timer_pkg::CNT_W-1:0] regRdata,
  output logic [twin_timer_pkg::NUM_TMR-1:0] irq
);
  tmrCmd_t                       cmd;
  logic [NUM_TMR-1:0][CNT_W-1:0] countNow;
  logic [NUM_TMR-1:0][CNT_W-1:0] reloadNow;
  logic [NUM_TMR-1:0]            expire;

  twin_timer_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .expire(expire),
    .countNow(countNow), .reloadNow(reloadNow), .cmd(cmd), .irq(irq)
  );

  twin_timer_datapath u_dp (
    .clk(clk), .rstN(rstN), .refTick(refTick), .fabricTick(fabricTick),
    .cmd(cmd), .wrData(regWdata), .countNow(countNow),
    .reloadNow(reloadNow), .expire(expire)
  );
endmodule

// File: rtl/twin_timer_checker.sv
module twin_timer_checker
  import twin_timer_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          regWe,
  input logic [ADDR_W-1:0]             regAddr,
  input logic [CNT_W-1:0]              regWdata,
  input logic [NUM_TMR-1:0]            irq,
  input logic [NUM_TMR-1:0]            expire,
  input logic [NUM_TMR-1:0]            enable,
  input logic [NUM_TMR-1:0]            autoReload,
  input logic [NUM_TMR-1:0]            wrValue,
  input logic [NUM_TMR-1:0][CNT_W-1:0] countNow
);
  for (genvar gi = 0; gi < NUM_TMR; gi++) begin : g_chk
    logic clrHit;
    assign clrHit = regWe && (regAddr == ADDR_W'(STAT_ADDR)) && !regWdata[statBit(gi)];

    a_r11_expiry_wins: assert property (@(posedge clk) disable iff (!rstN)
      expire[gi] |=> irq[gi]);

    a_r9_sticky: assert property (@(posedge clk) disable iff (!rstN)
      irq[gi] && !clrHit |=> irq[gi]);

    a_r9_zero_clears: assert property (@(posedge clk) disable iff (!rstN)
      clrHit && !expire[gi] |=> !irq[gi]);

    a_r10_no_spurious_irq: assert property (@(posedge clk) disable iff (!rstN)
      !irq[gi] && !expire[gi] |=> !irq[gi]);

    a_r6_disabled_holds: assert property (@(posedge clk) disable iff (!rstN)
      !enable[gi] && !wrValue[gi] |=> $stable(countNow[gi]));

    a_r6_disabled_silent: assert property (@(posedge clk) disable iff (!rstN)
      !enable[gi] |-> !expire[gi]);

    a_r5_oneshot_parks: assert property (@(posedge clk) disable iff (!rstN)
      expire[gi] && !autoReload[gi] && !wrValue[gi] |=> countNow[gi] == '0);
  end
endmodule

bind twin_countdown_timer twin_timer_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
  .regWdata(regWdata), .irq(irq), .expire(expire),
  .enable(cmd.enable), .autoReload(cmd.autoReload), .wrValue(cmd.wrValue),
  .countNow(countNow)
);

// File: tb/twin_countdown_timer_bench.sv
module twin_countdown_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8;

  typedef struct packed {
    logic [31:0] startVal;
    logic [31:0] relVal;
    logic        periodic;
    logic [7:0]  ticks;
    logic [31:0] expCount;
    logic [31:0] expStat;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{32'd5,        32'd9,        1'b1, 8'd3, 32'd2,        32'h0},
    '{32'd5,        32'd9,        1'b1, 8'd6, 32'd9,        32'h1},
    '{32'd2,        32'd7,        1'b0, 8'd5, 32'd0,        32'h1},
    '{32'd0,        32'd3,        1'b1, 8'd9, 32'd3,        32'h1},
    '{32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1, 8'd4, 32'hFFFFFFFB, 32'h0},
    '{32'd1,        32'd4,        1'b0, 8'd1, 32'd0,        32'h0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refTick = 1'b0;
  logic fabricTick = 1'b0;
  logic regWe = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [1:0]  irq;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  twin_countdown_timer #(.ADDR_W(ADDR_W)) u_twin_countdown_timer (
    .clk(clk), .rstN(rstN), .refTick(refTick), .fabricTick(fabricTick),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rdReg(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic pulseRef(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk) refTick = 1'b1;
      @(negedge clk) refTick = 1'b0;
    end
  endtask

  task automatic pulseFab(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk) fabricTick = 1'b1;
      @(negedge clk) fabricTick = 1'b0;
    end
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R12 reset state
    rdReg(8'h00, rd); check("R12 ctrl", rd, 32'h0);
    rdReg(8'h04, rd); check("R12 status", rd, 32'h0);
    rdReg(8'h14, rd); check("R12 value0", rd, 32'h0);
    check("R12 irq", {30'd0, irq}, 32'h0);

    // table: counter 0 on reference ticks (R3 R4 R5)
    foreach (VECS[v]) begin
      wrReg(8'h00, 32'h0);
      wrReg(8'h10, VECS[v].relVal);
      wrReg(8'h14, VECS[v].startVal);
      wrReg(8'h04, 32'h0);
      wrReg(8'h00, 32'h801 | (VECS[v].periodic ? 32'h2 : 32'h0));
      pulseRef(int'(VECS[v].ticks));
      rdReg(8'h14, rd); check($sformatf("R3/R4/R5 vec%0d count", v), rd, VECS[v].expCount);
      rdReg(8'h04, rd); check($sformatf("R4/R5 vec%0d status", v), rd, VECS[v].expStat);
    end

    // R1 readback and unmapped
    rdReg(8'h10, rd); check("R1 reload0 readback", rd, 32'd4);
    rdReg(8'h00, rd); check("R1 ctrl readback", rd, 32'h801);
    rdReg(8'h08, rd); check("R1 unmapped", rd, 32'h0);

    // R6 disabled counter ignores ticks
    wrReg(8'h00, 32'h800);
    wrReg(8'h14, 32'd7);
    wrReg(8'h04, 32'h0);
    pulseRef(3); pulseFab(3);
    rdReg(8'h14, rd); check("R6 disabled holds", rd, 32'd7);
    rdReg(8'h04, rd); check("R6 no event", rd, 32'h0);

    // R2 mid-run value write
    wrReg(8'h00, 32'h803);
    wrReg(8'h14, 32'd50);
    pulseRef(5);
    rdReg(8'h14, rd); check("R2 live count", rd, 32'd45);
    wrReg(8'h14, 32'd100);
    rdReg(8'h14, rd); check("R2 direct load", rd, 32'd100);
    pulseRef(1);
    rdReg(8'h14, rd); check("R2 count after load", rd, 32'd99);

    // R7 reference selected ignores fabric
    wrReg(8'h14, 32'd20);
    pulseFab(2);
    rdReg(8'h14, rd); check("R7 ref ignores fabric", rd, 32'd20);
    // R7 fabric selected (exponent 0) ignores reference
    wrReg(8'h00, 32'h003);
    pulseRef(3);
    rdReg(8'h14, rd); check("R7 fabric ignores ref", rd, 32'd20);
    pulseFab(3);
    rdReg(8'h14, rd); check("R7 fabric div1", rd, 32'd17);

    // R8 counter 1 prescaler, exponent 2, restart on enable rise
    wrReg(8'h00, 32'h0080000C);
    wrReg(8'h1C, 32'd10);
    pulseFab(3);
    rdReg(8'h1C, rd); check("R8 partial prescale", rd, 32'd10);
    wrReg(8'h00, 32'h00800000);
    wrReg(8'h00, 32'h0080000C);
    pulseFab(1);
    rdReg(8'h1C, rd); check("R8 prescaler restarted", rd, 32'd10);
    pulseFab(3);
    rdReg(8'h1C, rd); check("R8 first divided tick", rd, 32'd9);
    pulseFab(8);
    rdReg(8'h1C, rd); check("R8 divide by 4", rd, 32'd7);

    // R9 R10 both flags, write-zero clear
    wrReg(8'h00, 32'h1805);
    wrReg(8'h14, 32'd0);
    wrReg(8'h1C, 32'd0);
    wrReg(8'h04, 32'h0);
    pulseRef(1);
    rdReg(8'h04, rd); check("R9 both set", rd, 32'h101);
    check("R10 irq both", {30'd0, irq}, 32'h3);
    wrReg(8'h04, 32'h1);
    rdReg(8'h04, rd); check("R9 one keeps zero clears", rd, 32'h001);
    check("R10 irq follows", {30'd0, irq}, 32'h1);
    wrReg(8'h04, 32'h100);
    rdReg(8'h04, rd); check("R9 clear bit0", rd, 32'h0);

    // R5 parked one-shot stays silent, re-arms on value write
    pulseRef(3);
    rdReg(8'h04, rd); check("R5 no second event", rd, 32'h0);
    rdReg(8'h14, rd); check("R5 stays zero", rd, 32'h0);
    wrReg(8'h14, 32'd1);
    pulseRef(2);
    rdReg(8'h04, rd); check("R5 re-armed event", rd, 32'h1);

    // R11 expiry and clear in the same cycle
    wrReg(8'h00, 32'h803);
    wrReg(8'h10, 32'd5);
    wrReg(8'h14, 32'd0);
    wrReg(8'h04, 32'h0);
    @(negedge clk);
    refTick = 1'b1; regWe = 1'b1; regAddr = 8'h04; regWdata = 32'h0;
    @(negedge clk);
    refTick = 1'b0; regWe = 1'b0;
    rdReg(8'h04, rd); check("R11 expiry wins", rd, 32'h1);
    check("R11 irq set", {30'd0, irq}, 32'h1);
    rdReg(8'h14, rd); check("R4 reloaded", rd, 32'd5);

    finished = 1'b1;
    summary();
  end
endmodule